// File: doc/BRIEF.md
# UART Transmitter with Line Collision Watch

This block serialises 9-bit words onto a single-wire line and watches the line while it does so. Each frame is a low start bit, nine data bits sent least significant first, and a high stop bit. One bit lasts one period of the transfer-clock enable `bit_tick`. Software writes a word into a holding register and sets the transmit enable. A frame starts when both are present. At that moment the word moves into the shift register and the holding register empties.

While a frame is on the line, the block reads the line back on `rx_pin` through a two-stage synchroniser, with optional inversion. It compares that level with the bit it is driving. The comparison happens either on each `bit_tick` or on an external one-shot strobe, chosen by `cmp_on_strobe`. A mismatch sets a sticky collision flag. When `col_autoclr` is high, the mismatch also drops the transmit enable and abandons the frame at a bit boundary. The frame start can follow the transfer clock, or it can follow a chosen edge on the read-back line. In the second case, other stations on a shared line can set the timing.

Top module: `uart_coltx`

## Requirements
- R1: After reset `tx_pin` is 1, and `tx_enable`, `hold_full`, `busy` and `col_flag` are 0.
- R2: A frame drives 0 for the start bit, then word bits 0 to 8 in that order, then 1 for the stop bit. Each bit lasts one `bit_tick` period. `tx_pin` is 1 whenever `busy` is 0.
- R3: A frame starts only when `tx_enable` and `hold_full` are both 1. The start empties the holding register, unless `wr_load` writes it in that same cycle.
- R4: With `start_on_edge`=0, the start bit begins at the first `bit_tick` after the start condition holds. This is within one bit period plus two clocks of the write.
- R5: With `start_on_edge`=1, the start bit begins three clocks after the chosen edge of the read-back level reaches `rx_pin`. The edge is falling with `edge_rising`=0 and rising with `edge_rising`=1. The opposite edge does not start a frame, and neither does an edge that arrives while the start condition is false.
- R6: With `cmp_on_strobe`=0, the line is compared only on `bit_tick`, at the end of each bit. With `cmp_on_strobe`=1, it is compared only on `cmp_strobe` pulses, and `bit_tick` compares nothing.
- R7: The compared level is `rx_pin` XOR `rx_invert`. Start, data and stop bits are all compared. A compare in the first three clocks after `tx_pin` changes is skipped, so a clean loop-back never flags.
- R8: A mismatch sets `col_flag` on the next clock. The flag stays set until a `col_clr` pulse, and a new mismatch wins over a clear in the same cycle.
- R9: With `col_autoclr`=1, a mismatch clears `tx_enable` in the same clock that `col_flag` sets. `tx_pin` then returns to 1 at the next bit boundary, or at the current one if the mismatch was found on `bit_tick`, and the remaining bits are dropped. With `col_autoclr`=0, the frame runs to its end and `tx_enable` stays 1.
- R10: A set `col_flag` does not block transmission. A frame starts again once `tx_enable` is written to 1 and a word is held.
- R11: `en_set` sets and `en_clr` clears `tx_enable`. An automatic clear wins over `en_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Transfer-clock enable, one pulse per bit |
| cmp_strobe | input | 1 | External compare strobe (one-shot) |
| rx_pin | input | 1 | Line read-back, asynchronous |
| tx_pin | output | 1 | Serial output, idle high |
| wr_data | input | DATA_W | Word to transmit |
| wr_load | input | 1 | Write `wr_data` into the holding register |
| en_set | input | 1 | Set transmit enable |
| en_clr | input | 1 | Clear transmit enable |
| col_clr | input | 1 | Clear the collision flag |
| cmp_on_strobe | input | 1 | 0: compare on `bit_tick`; 1: compare on `cmp_strobe` |
| col_autoclr | input | 1 | Drop enable and abandon the frame on collision |
| start_on_edge | input | 1 | 0: start on transfer clock; 1: start on line edge |
| edge_rising | input | 1 | Edge-start polarity: 0 falling, 1 rising |
| rx_invert | input | 1 | Invert the read-back level |
| tx_enable | output | 1 | Transmit enable state |
| hold_full | output | 1 | Holding register occupied |
| busy | output | 1 | Frame in progress |
| col_flag | output | 1 | Sticky collision flag |

## Verification
`tx_pin` changes one clock after the `bit_tick` edge that moves it. The bench therefore samples each bit four clocks into its eight-clock period, on a falling edge. A mismatch found at a compare edge shows on `col_flag` and `tx_enable` one clock later. With the strobe, the abandoned bit stays on the line until the next tick. The bench checks before that tick and after it. An edge-started frame is due exactly three clocks after the edge is driven: two synchroniser stages plus the start register. The bench checks the line at the second and at the third falling clock edge after driving it.

// File: rtl/uart_coltx_pkg.sv
package uart_coltx_pkg;

    localparam int DEF_DATA_W  = 9;
    localparam int DEF_SYNC_ST = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEND
    } tx_state_e;

    typedef struct packed {
        logic cmp_on_strobe;
        logic col_autoclr;
        logic start_on_edge;
        logic edge_rising;
        logic rx_invert;
    } coltx_cfg_t;

    // clocks a freshly driven bit needs before the read-back is trusted
    function automatic int settle_clocks(input int sync_stages);
        return sync_stages + 1;
    endfunction

endpackage

// File: rtl/uart_coltx_rx_front.sv
module uart_coltx_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_pin,
    input  logic rx_invert,
    input  logic edge_rising,
    output logic rx_lvl,
    output logic rx_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            lvl_d_q <= ~rx_invert;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], rx_pin};
            lvl_d_q <= rx_lvl;
        end
    end

    assign rx_lvl  = sync_q[SYNC_STAGES-1] ^ rx_invert;
    assign rx_edge = edge_rising ? (rx_lvl & ~lvl_d_q) : (~rx_lvl & lvl_d_q);

endmodule

// File: rtl/uart_coltx_tx_seq.sv
module uart_coltx_tx_seq
    import uart_coltx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int SETTLE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              ready,
    input  logic              start_on_edge,
    input  logic              rx_edge,
    input  logic              abort_now,
    input  logic [DATA_W-1:0] hold_data,
    output logic              tx_bit,
    output logic              busy,
    output logic              take,
    output logic              settled
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int CNT_W   = $clog2(SETTLE + 1);

    tx_state_e          state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   settle_q;
    logic               abandon_q;
    logic               tx_q;
    logic               last_bit;
    logic               boundary;

    assign frame    = {1'b1, hold_data, 1'b0};
    assign take     = (state_q == ST_ARM) && ready && (start_on_edge ? rx_edge : bit_tick);
    assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));
    assign boundary = (state_q == ST_SEND) && bit_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            sh_q      <= '0;
            abandon_q <= 1'b0;
            tx_q      <= 1'b1;
            settle_q  <= '0;
        end else begin
            if (take || boundary) begin
                settle_q <= '0;
            end else if (settle_q != CNT_W'(SETTLE)) begin
                settle_q <= settle_q + 1'b1;
            end

            case (state_q)
                ST_IDLE: begin
                    if (ready) state_q <= ST_ARM;
                end
                ST_ARM: begin
                    if (!ready) begin
                        state_q <= ST_IDLE;
                    end else if (take) begin
                        state_q   <= ST_SEND;
                        tx_q      <= frame[0];
                        sh_q      <= frame >> 1;
                        idx_q     <= '0;
                        abandon_q <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (abort_now) abandon_q <= 1'b1;
                    if (bit_tick) begin
                        if (abandon_q || abort_now || last_bit) begin
                            state_q   <= ST_IDLE;
                            tx_q      <= 1'b1;
                            abandon_q <= 1'b0;
                        end else begin
                            tx_q  <= sh_q[0];
                            sh_q  <= sh_q >> 1;
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_bit  = tx_q;
    assign busy    = (state_q == ST_SEND);
    assign settled = (settle_q == CNT_W'(SETTLE));

endmodule

// File: rtl/uart_coltx_col_detect.sv
module uart_coltx_col_detect (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic settled,
    input  logic tx_bit,
    input  logic rx_lvl,
    input  logic cmp_on_strobe,
    input  logic bit_tick,
    input  logic cmp_strobe,
    input  logic col_clr,
    output logic col_event,
    output logic col_flag
);
    logic sample_now;
    logic flag_q;

    assign sample_now = busy && settled && (cmp_on_strobe ? cmp_strobe : bit_tick);
    assign col_event  = sample_now && (tx_bit != rx_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (col_event) begin
            flag_q <= 1'b1;
        end else if (col_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign col_flag = flag_q;

endmodule

// File: rtl/uart_coltx.sv
module uart_coltx
    import uart_coltx_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int SYNC_STAGES = DEF_SYNC_ST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              cmp_strobe,
    input  logic              rx_pin,
    output logic              tx_pin,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_load,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              col_clr,
    input  logic              cmp_on_strobe,
    input  logic              col_autoclr,
    input  logic              start_on_edge,
    input  logic              edge_rising,
    input  logic              rx_invert,
    output logic              tx_enable,
    output logic              hold_full,
    output logic              busy,
    output logic              col_flag
);
    localparam int SETTLE = settle_clocks(SYNC_STAGES);

    coltx_cfg_t        cfg;
    logic              rx_lvl;
    logic              rx_edge;
    logic              tx_bit;
    logic              take;
    logic              settled;
    logic              col_event;
    logic              abort_now;
    logic              ready;
    logic              en_q;
    logic              full_q;
    logic [DATA_W-1:0] hold_q;

    assign cfg = '{cmp_on_strobe: cmp_on_strobe, col_autoclr: col_autoclr,
                   start_on_edge: start_on_edge, edge_rising: edge_rising,
                   rx_invert: rx_invert};

    assign ready     = en_q & full_q;
    assign abort_now = col_event & cfg.col_autoclr;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (abort_now) begin
            en_q <= 1'b0;
        end else if (en_set) begin
            en_q <= 1'b1;
        end else if (en_clr) begin
            en_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (wr_load) begin
            full_q <= 1'b1;
            hold_q <= wr_data;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    uart_coltx_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_rx_front (
        .clk         (clk),
        .rst         (rst),
        .rx_pin      (rx_pin),
        .rx_invert   (cfg.rx_invert),
        .edge_rising (cfg.edge_rising),
        .rx_lvl      (rx_lvl),
        .rx_edge     (rx_edge)
    );

    uart_coltx_tx_seq #(.DATA_W(DATA_W), .SETTLE(SETTLE)) u_tx_seq (
        .clk           (clk),
        .rst           (rst),
        .bit_tick      (bit_tick),
        .ready         (ready),
        .start_on_edge (cfg.start_on_edge),
        .rx_edge       (rx_edge),
        .abort_now     (abort_now),
        .hold_data     (hold_q),
        .tx_bit        (tx_bit),
        .busy          (busy),
        .take          (take),
        .settled       (settled)
    );

    uart_coltx_col_detect u_col_detect (
        .clk           (clk),
        .rst           (rst),
        .busy          (busy),
        .settled       (settled),
        .tx_bit        (tx_bit),
        .rx_lvl        (rx_lvl),
        .cmp_on_strobe (cfg.cmp_on_strobe),
        .bit_tick      (bit_tick),
        .cmp_strobe    (cmp_strobe),
        .col_clr       (col_clr),
        .col_event     (col_event),
        .col_flag      (col_flag)
    );

    assign tx_pin    = tx_bit;
    assign tx_enable = en_q;
    assign hold_full = full_q;

endmodule

// File: rtl/uart_coltx_chk.sv
module uart_coltx_chk (
    input logic clk,
    input logic rst,
    input logic tx_pin,
    input logic busy,
    input logic bit_tick,
    input logic start_on_edge,
    input logic col_flag,
    input logic col_clr,
    input logic col_autoclr,
    input logic tx_enable,
    input logic hold_full,
    input logic wr_load
);
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_pin);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_pin);

    assert_start_needs_word_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(hold_full) && $past(tx_enable));

    assert_word_taken_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) && !$past(wr_load) |-> !hold_full);

    assert_start_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) && !start_on_edge |-> $past(bit_tick));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        col_flag && !col_clr |=> col_flag);

    assert_autoclr_drops_enable_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(col_flag) && $past(col_autoclr) |-> !tx_enable);

endmodule

bind uart_coltx uart_coltx_chk u_chk (.*);

// File: tb/uart_coltx_tb.sv
`timescale 1ns/1ps
module uart_coltx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick, cmp_strobe, rx_pin, tx_pin;
    logic [8:0] wr_data = '0;
    logic       wr_load = 0, en_set = 0, en_clr = 0, col_clr = 0;
    logic       cmp_on_strobe = 0, col_autoclr = 1, start_on_edge = 0;
    logic       edge_rising = 0, rx_invert = 0;
    logic       tx_enable, hold_full, busy, col_flag;
    logic       force_en = 0, force_val = 1, strobe_en = 1;
    logic [2:0] phase = '0;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;
    always @(negedge clk) phase <= rst ? 3'd0 : phase + 3'd1;
    assign bit_tick   = (phase == 3'd7);
    assign cmp_strobe = strobe_en && (phase == 3'd3);
    assign rx_pin     = force_en ? force_val : (tx_pin ^ rx_invert);

    uart_coltx u_dut (.*);

    // {rx_invert, cmp_on_strobe, word}
    localparam logic [10:0] VEC [0:3] = '{
        {1'b0, 1'b0, 9'h1A5}, {1'b1, 1'b0, 9'h000},
        {1'b0, 1'b1, 9'h1FF}, {1'b1, 1'b1, 9'h0F3}};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_enable(input logic [8:0] d);
        @(negedge clk);
        wr_data = d; wr_load = 1; en_set = 1;
        @(negedge clk);
        wr_load = 0; en_set = 0;
    endtask

    task automatic wait_fall(output int k);
        k = 0;
        while (tx_pin !== 1'b0 && k < 40) begin
            @(negedge clk);
            k++;
        end
    endtask

    // stimulus through the start bit's falling edge, then every bit at mid-period
    task automatic run_frame(input logic [8:0] d, input logic exp_col);
        int k;
        load_enable(d);
        wait_fall(k);
        chk(k <= 11, "R4 start latency", k, 11);
        chk(hold_full == 0, "R3 holding emptied", hold_full, 0);
        repeat (4) @(negedge clk);
        for (int b = 0; b < 11; b++) begin
            logic e;
            e = (b == 0) ? 1'b0 : (b == 10) ? 1'b1 : d[b-1];
            chk(tx_pin == e, "R2 frame bit", tx_pin, e);
            repeat (8) @(negedge clk);
        end
        chk(tx_pin == 1 && busy == 0, "R2 idle after stop", tx_pin, 1);
        chk(col_flag == exp_col, "R7 R8 collision flag", col_flag, exp_col);
    endtask

    task automatic pulse_clr();
        @(negedge clk); col_clr = 1;
        @(negedge clk); col_clr = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 150 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k, lows;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(tx_pin == 1, "R1 tx idle", tx_pin, 1);
        chk(tx_enable == 0 && hold_full == 0, "R1 enable and holding", tx_enable, 0);
        chk(col_flag == 0 && busy == 0, "R1 flag and busy", col_flag, 0);

        // table walk: clean loop-back frames, various inversion and sampling modes
        for (int v = 0; v < 4; v++) begin
            rx_invert = VEC[v][10]; cmp_on_strobe = VEC[v][9];
            repeat (4) @(negedge clk);
            run_frame(VEC[v][8:0], 1'b0);
        end
        chk(tx_enable == 1, "R11 enable kept", tx_enable, 1);
        rx_invert = 0; cmp_on_strobe = 0;

        // R11 clear enable, then R3 a held word without enable never goes out
        @(negedge clk); en_clr = 1; @(negedge clk); en_clr = 0;
        chk(tx_enable == 0, "R11 en_clr", tx_enable, 1'b0);
        @(negedge clk); wr_data = 9'h055; wr_load = 1; @(negedge clk); wr_load = 0;
        lows = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (!tx_pin) lows++; end
        chk(lows == 0, "R3 no start without enable", lows, 0);
        chk(hold_full == 1, "R3 word still held", hold_full, 1);

        // R9 auto-clear with tick compare: abandon at the boundary of the start bit
        force_en = 1; force_val = 1;
        @(negedge clk); en_set = 1; @(negedge clk); en_set = 0;
        wait_fall(k);
        repeat (4) @(negedge clk);
        chk(col_flag == 0, "R6 no compare mid-bit in tick mode", col_flag, 0);
        repeat (8) @(negedge clk);
        chk(col_flag == 1, "R8 flag set", col_flag, 1);
        chk(tx_enable == 0, "R9 enable auto-cleared", tx_enable, 0);
        chk(tx_pin == 1 && busy == 0, "R9 abandoned at boundary", tx_pin, 1);

        // R10 new frame while flag still set; flag remains sticky (R8)
        force_en = 0;
        repeat (4) @(negedge clk);
        run_frame(9'h12C, 1'b1);
        chk(tx_enable == 1, "R10 enable rewritten", tx_enable, 1);
        pulse_clr();
        chk(col_flag == 0, "R8 cleared by col_clr", col_flag, 0);

        // R9 without auto-clear the frame runs to the end
        col_autoclr = 0; force_en = 1; force_val = 1;
        run_frame(9'h0AA, 1'b1);
        chk(tx_enable == 1, "R9 enable kept without auto-clear", tx_enable, 1);
        force_en = 0; pulse_clr(); col_autoclr = 1;

        // R6 strobe mode with no strobes: mismatching line is never compared
        cmp_on_strobe = 1; strobe_en = 0; force_en = 1; force_val = 1;
        run_frame(9'h155, 1'b0);
        chk(tx_enable == 1, "R6 tick ignored in strobe mode", tx_enable, 1);

        // R6 R9 strobe compare mid-bit; bit held until the next tick
        strobe_en = 1;
        load_enable(9'h000);
        wait_fall(k);
        repeat (6) @(negedge clk);
        chk(col_flag == 1 && tx_enable == 0, "R6 strobe compare", col_flag, 1);
        chk(tx_pin == 0 && busy == 1, "R9 bit held until boundary", tx_pin, 0);
        repeat (4) @(negedge clk);
        chk(tx_pin == 1 && busy == 0, "R9 idle after boundary", tx_pin, 1);
        force_en = 0; pulse_clr(); cmp_on_strobe = 0;
        repeat (4) @(negedge clk);

        // R5 edge start, falling polarity
        start_on_edge = 1; edge_rising = 0; force_en = 1; force_val = 1;
        repeat (5) @(negedge clk);
        force_val = 0;
        repeat (5) @(negedge clk);
        load_enable(9'h1E1);
        lows = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (!tx_pin) lows++; end
        chk(lows == 0, "R5 early edge ignored", lows, 0);
        force_val = 1;
        lows = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (!tx_pin) lows++; end
        chk(lows == 0, "R5 wrong edge ignored", lows, 0);
        force_val = 0;
        repeat (2) @(negedge clk);
        chk(tx_pin == 1, "R5 not yet at two clocks", tx_pin, 1);
        @(negedge clk);
        chk(tx_pin == 0, "R5 start three clocks after falling edge", tx_pin, 0);
        force_en = 0;
        wait_idle();
        chk(col_flag == 0 && hold_full == 0, "R7 edge frame clean", col_flag, 0);

        // R5 edge start, rising polarity
        edge_rising = 1; force_en = 1; force_val = 0;
        repeat (5) @(negedge clk);
        force_val = 1;
        repeat (5) @(negedge clk);
        load_enable(9'h0C3);
        lows = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (!tx_pin) lows++; end
        chk(lows == 0, "R5 early rising edge ignored", lows, 0);
        force_val = 0;
        lows = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (!tx_pin) lows++; end
        chk(lows == 0, "R5 falling edge ignored", lows, 0);
        force_val = 1;
        repeat (2) @(negedge clk);
        chk(tx_pin == 1, "R5 rising not yet", tx_pin, 1);
        @(negedge clk);
        chk(tx_pin == 0, "R5 start three clocks after rising edge", tx_pin, 0);
        force_en = 0;
        wait_idle();
        chk(col_flag == 0 && busy == 0, "R7 settle window skips fresh bit", col_flag, 0);
        start_on_edge = 0;

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule